// File: doc/BRIEF.md
# Quad Converter Double-Buffered Register Front End

This block is the synchronous digital front end for a four-channel 12-bit digital-to-analog converter. A host drives a parallel bus with the following signals:

- an active-low chip select;
- a 2-bit channel address;
- a 3-bit quad select;
- a shared 12-bit bidirectional data port;
- four active-low strobes for load, mode, transparent and read.

The front end samples this bus on the system clock. It first passes every bus signal through a two-flop synchronizer. It then detects the falling edge of the synchronized chip select and commits the access decoded on that cycle. The block answers only when the quad-select lines equal the `QUAD_ID` strap parameter.

Each channel holds two registers:

- an input (first-rank) register, written one channel at a time;
- an output (second-rank) register, which drives the converter core.

A single update access moves all four input registers into the output registers together, so every output changes in the same cycle. A transparent mode writes bus data into both ranks on every cycle while it is held. This applies to all channels or only the addressed one.

A separate two-rank mode register holds one polarity bit per channel (0 unipolar, 1 bipolar). The host can read back either the output code of a channel or the mode register over the same data port. The port is high-impedance at all other times. An asynchronous active-low reset clears all state.

Top module: `qdac_regif`

## Requirements
- R1: When chip select falls with read, mode and transparent strobes high and load strobe low, the data word is stored in the input register of the addressed channel only. Address 0 is channel A, 1 is B, 2 is C and 3 is D. `code_o` does not change.
- R2: When chip select falls with load, mode, transparent and read strobes all high, all four input registers are copied into the output registers in one cycle, whatever the address. Channel n occupies `code_o[12n+11:12n]`.
- R3: While chip select and read are low with mode and transparent high, the port returns the output code of the addressed channel. Otherwise the block does not drive the port.
- R4: While chip select and the transparent strobe are low, with mode and read high and load high, the data word is written into both ranks of all four channels on every cycle.
- R5: In the same transparent condition with load low, only the addressed channel's two ranks follow the data word.
- R6: When chip select falls with mode low and read high, the low 4 bits of the data go into the mode input rank if load is low. If load is high, the mode input rank is copied to the mode output rank. Only the copy changes `bip_o`, where bit n is channel n's polarity.
- R7: While chip select, mode and read are low with transparent high, the port returns the mode output rank in bits 3:0 and zero in bits 11:4.
- R8: Driving reset low at any moment clears all channel registers and both mode ranks without waiting for a clock.
- R9: When the quad select differs from `QUAD_ID`, writes, updates, transparent loads and reads have no effect, and the port stays undriven.
- R10: After reset every code is 0x000 and every channel is unipolar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; falling edge commits an access |
| ld_n | input | 1 | Load strobe: low targets the input rank or one channel, high targets transfer or all channels |
| ms_n | input | 1 | Low addresses the mode register |
| tr_n | input | 1 | Low enables transparent loading |
| rd_n | input | 1 | Low requests readback |
| addr | input | 2 | Channel address |
| qsel | input | 3 | Quad select, compared with `QUAD_ID` |
| data_io | inout | 12 | Bidirectional data port |
| code_o | output | 48 | Output-rank codes, channel n in bits 12n+11:12n |
| bip_o | output | 4 | Mode output rank, 1 = bipolar |

## Verification
Directed steps come first. The bench writes distinct codes to each channel and checks that the outputs hold until an update with an unrelated address moves all four channels at once. Mode writes and transfers are checked the same way, which separates the first rank from the second. Transparent passes with the load strobe high and low, with a data change mid-hold, show the difference between all-channel and single-channel pass-through. A mismatched quad select, and a reset pulse placed between clock edges, show the ignore rule and the asynchronous clear. A seeded random mix of all access kinds is then checked against a reference model in the bench, with readback of codes and mode after each step.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    parameter int NCH = 4;
    parameter int DW  = 12;
    parameter int AW  = $clog2(NCH);
    parameter int QW  = 3;

    typedef struct packed {
        logic          cs_n;
        logic          ld_n;
        logic          ms_n;
        logic          tr_n;
        logic          rd_n;
        logic [AW-1:0] addr;
        logic [QW-1:0] qsel;
        logic [DW-1:0] data;
    } bus_t;

    localparam int BUSW = $bits(bus_t);
    localparam bus_t BUS_IDLE = '{cs_n: 1'b1, ld_n: 1'b1, ms_n: 1'b1,
                                  tr_n: 1'b1, rd_n: 1'b1, addr: '0,
                                  qsel: '0, data: '0};

    typedef struct packed {
        logic [DW-1:0] r1;
        logic [DW-1:0] r2;
    } chan_st_t;

    typedef struct packed {
        logic           cs_prev;
        logic [NCH-1:0] m1;
        logic [NCH-1:0] m2;
        logic           oe;
        logic [DW-1:0]  rdat;
    } top_st_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  bus_t           bus,
    input  logic           cs_fall,
    input  logic           qmatch,
    output logic [NCH-1:0] r1_we,
    output logic [NCH-1:0] r2_cp,
    output logic [NCH-1:0] r2_tr,
    output logic           mode_wr,
    output logic           mode_xfer,
    output logic           rd_req,
    output logic           rd_mode
);
    logic [NCH-1:0] sel;
    logic           cmd;
    logic           tr_hold;

    always_comb begin
        for (int i = 0; i < NCH; i++) sel[i] = (bus.addr == AW'(i));
        cmd     = qmatch & cs_fall & bus.rd_n;
        tr_hold = qmatch & ~bus.cs_n & bus.rd_n & bus.ms_n & ~bus.tr_n;

        r1_we = '0;
        r2_cp = '0;
        r2_tr = '0;
        if (bus.ms_n && bus.tr_n && cmd) begin
            if (bus.ld_n) r2_cp = '1;
            else          r1_we = sel;
        end
        if (tr_hold) r2_tr = bus.ld_n ? '1 : sel;

        mode_wr   = cmd & ~bus.ms_n & ~bus.ld_n;
        mode_xfer = cmd & ~bus.ms_n &  bus.ld_n;
        rd_req    = qmatch & ~bus.cs_n & ~bus.rd_n & bus.tr_n;
        rd_mode   = ~bus.ms_n;
    end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
    import qdac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we1,
    input  logic          cp2,
    input  logic          trn,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] code
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trn) begin
            st_d.r1 = din;
            st_d.r2 = din;
        end else begin
            if (we1) st_d.r1 = din;
            if (cp2) st_d.r2 = st_q.r1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.r2;
endmodule

// File: rtl/qdac_regif.sv
module qdac_regif
    import qdac_pkg::*;
#(
    parameter logic [QW-1:0] QUAD_ID     = 3'd5,
    parameter int            SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ld_n,
    input  logic              ms_n,
    input  logic              tr_n,
    input  logic              rd_n,
    input  logic [AW-1:0]     addr,
    input  logic [QW-1:0]     qsel,
    inout  wire  [DW-1:0]     data_io,
    output logic [NCH*DW-1:0] code_o,
    output logic [NCH-1:0]    bip_o
);
    bus_t bus_raw, bus_s;
    top_st_t st_d, st_q;

    logic           cs_fall, qmatch;
    logic [NCH-1:0] r1_we, r2_cp, r2_tr;
    logic           mode_wr, mode_xfer, rd_req, rd_mode;
    logic           any_load, rd_drive;
    logic [DW-1:0]  codes [NCH];

    always_comb begin
        bus_raw      = BUS_IDLE;
        bus_raw.cs_n = cs_n;
        bus_raw.ld_n = ld_n;
        bus_raw.ms_n = ms_n;
        bus_raw.tr_n = tr_n;
        bus_raw.rd_n = rd_n;
        bus_raw.addr = addr;
        bus_raw.qsel = qsel;
        bus_raw.data = data_io;
    end

    qdac_sync #(.W(BUSW), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    assign qmatch  = (bus_s.qsel == QUAD_ID);
    assign cs_fall = st_q.cs_prev & ~bus_s.cs_n;

    qdac_decode u_dec (
        .bus(bus_s), .cs_fall(cs_fall), .qmatch(qmatch),
        .r1_we(r1_we), .r2_cp(r2_cp), .r2_tr(r2_tr),
        .mode_wr(mode_wr), .mode_xfer(mode_xfer),
        .rd_req(rd_req), .rd_mode(rd_mode)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qdac_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .we1(r1_we[g]), .cp2(r2_cp[g]), .trn(r2_tr[g]),
            .din(bus_s.data), .code(codes[g])
        );
        assign code_o[g*DW +: DW] = codes[g];
    end

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = bus_s.cs_n;
        if (mode_wr)   st_d.m1 = bus_s.data[NCH-1:0];
        if (mode_xfer) st_d.m2 = st_q.m1;
        st_d.oe = rd_req;
        if (rd_mode) st_d.rdat = {{(DW-NCH){1'b0}}, st_q.m2};
        else         st_d.rdat = codes[bus_s.addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_load = |{r1_we, r2_cp, r2_tr};
    assign rd_drive = st_q.oe;
    assign bip_o    = st_q.m2;
    assign data_io  = rd_drive ? st_q.rdat : {DW{1'bz}};
endmodule

// File: rtl/qdac_regif_chk.sv
module qdac_regif_chk
    import qdac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*DW-1:0] code_o,
    input logic [NCH-1:0]    bip_o,
    input logic              cs_fall,
    input logic              any_load,
    input logic              mode_xfer,
    input logic              qmatch,
    input logic              rd_drive,
    input logic              rd_s_n,
    input logic              cs_s_n
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_clears: assert (code_o == '0 && bip_o == '0)
                else $error("R8 state not cleared under reset");
        end
    end

    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !cs_fall);

    a_r2_codes_need_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $past(any_load));

    a_r6_polarity_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bip_o) |-> $past(mode_xfer));

    a_r9_drive_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_drive) |-> $past(qmatch));

    a_r3_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_drive) |-> $past(!rd_s_n && !cs_s_n));
endmodule

bind qdac_regif qdac_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .bip_o(bip_o),
    .cs_fall(cs_fall), .any_load(any_load), .mode_xfer(mode_xfer),
    .qmatch(qmatch), .rd_drive(rd_drive),
    .rd_s_n(bus_s.rd_n), .cs_s_n(bus_s.cs_n)
);

// File: tb/tb_qdac_regif.sv
module tb_qdac_regif;
    localparam logic [2:0] QID = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ld_n = 1'b1, ms_n = 1'b1, tr_n = 1'b1, rd_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [2:0]  qsel = QID;
    logic [11:0] tb_drv = '0;
    logic        tb_en = 1'b0;
    wire  [11:0] data_io;
    logic [47:0] code_o;
    logic [3:0]  bip_o;

    int total = 0, bad = 0;
    logic done = 1'b0;

    logic [11:0] r1 [4];
    logic [11:0] r2 [4];
    logic [3:0]  m1, m2;

    assign data_io = tb_en ? tb_drv : 12'bz;

    always #4 clk = ~clk;

    qdac_regif #(.QUAD_ID(QID)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ld_n(ld_n), .ms_n(ms_n),
        .tr_n(tr_n), .rd_n(rd_n), .addr(addr), .qsel(qsel),
        .data_io(data_io), .code_o(code_o), .bip_o(bip_o)
    );

    function automatic logic [47:0] exp_codes();
        return {r2[3], r2[2], r2[1], r2[0]};
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin r1[i] = '0; r2[i] = '0; end
        m1 = '0; m2 = '0;
    endtask

    task automatic check_outs(input string req);
        chk(req, code_o, exp_codes());
        chk(req, {44'd0, bip_o}, {44'd0, m2});
    endtask

    // Write-type access; the bench keeps driving the port, so the value seen
    // there must be its own (R3: block silent outside reads).
    task automatic wr(input logic ms, input logic ld, input logic [1:0] a,
                      input logic [11:0] d, input logic [2:0] q);
        @(negedge clk);
        ms_n = ms; ld_n = ld; tr_n = 1'b1; rd_n = 1'b1;
        addr = a; qsel = q; tb_drv = d; tb_en = 1'b1;
        wait_n(1);
        cs_n = 1'b0;
        wait_n(6);
        chk("R3 port undriven during write", {36'd0, data_io}, {36'd0, d});
        cs_n = 1'b1;
        wait_n(6);
        ms_n = 1'b1; ld_n = 1'b1; qsel = QID;
    endtask

    task automatic rd(input logic ms, input logic [1:0] a, output logic [11:0] v);
        @(negedge clk);
        ms_n = ms; ld_n = 1'b1; tr_n = 1'b1; addr = a; qsel = QID; tb_en = 1'b0;
        rd_n = 1'b0;
        wait_n(1);
        cs_n = 1'b0;
        wait_n(6);
        v = data_io;
        cs_n = 1'b1; rd_n = 1'b1;
        wait_n(6);
        ms_n = 1'b1; tb_en = 1'b1;
    endtask

    task automatic transp(input logic ld, input logic [1:0] a,
                          input logic [11:0] d1, input logic [11:0] d2, input string req);
        @(negedge clk);
        ms_n = 1'b1; rd_n = 1'b1; ld_n = ld; addr = a; qsel = QID;
        tb_en = 1'b1; tb_drv = d1; tr_n = 1'b0;
        wait_n(1);
        cs_n = 1'b0;
        wait_n(6);
        for (int i = 0; i < 4; i++)
            if (ld || a == 2'(i)) begin r1[i] = d1; r2[i] = d1; end
        chk(req, code_o, exp_codes());
        tb_drv = d2;
        wait_n(6);
        for (int i = 0; i < 4; i++)
            if (ld || a == 2'(i)) begin r1[i] = d2; r2[i] = d2; end
        chk(req, code_o, exp_codes());
        cs_n = 1'b1; tr_n = 1'b1;
        wait_n(6);
        ld_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        void'($urandom(32'h0BADF00D));
        model_clear();
        tb_en = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        check_outs("R10 reset state");
        rd(1'b1, 2'd2, v);
        chk("R10 reset code readback", {36'd0, v}, 48'd0);

        // R1: load each channel's first rank, outputs hold
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 1'b0, 2'(i), 12'h111 * 12'(i + 1), QID);
            r1[i] = 12'h111 * 12'(i + 1);
        end
        check_outs("R1 input rank hidden until update");
        // R2: global update, address ignored
        wr(1'b1, 1'b1, 2'd1, 12'hFFF, QID);
        for (int i = 0; i < 4; i++) r2[i] = r1[i];
        check_outs("R2 update copies all channels");
        // R3: readback of each channel
        for (int i = 0; i < 4; i++) begin
            rd(1'b1, 2'(i), v);
            chk("R3 code readback", {36'd0, v}, {36'd0, r2[i]});
        end
        // R6: mode first rank does not reach outputs
        wr(1'b0, 1'b0, 2'd0, 12'hFA5, QID);
        m1 = 4'h5;
        check_outs("R6 mode input rank hidden");
        wr(1'b0, 1'b1, 2'd3, 12'h000, QID);
        m2 = m1;
        check_outs("R6 mode transfer");
        rd(1'b0, 2'd1, v);
        chk("R7 mode readback", {36'd0, v}, {44'd0, m2});
        // R4 / R5
        transp(1'b1, 2'd0, 12'h3C3, 12'h5A1, "R4 transparent all");
        transp(1'b0, 2'd2, 12'h0F0, 12'h7E7, "R5 transparent single");
        // R9: mismatched quad select
        wr(1'b1, 1'b0, 2'd0, 12'h999, 3'd2);
        wr(1'b1, 1'b1, 2'd0, 12'h999, 3'd2);
        wr(1'b0, 1'b0, 2'd0, 12'h00A, 3'd2);
        wr(1'b0, 1'b1, 2'd0, 12'h00A, 3'd2);
        check_outs("R9 mismatch ignored");
        wr(1'b1, 1'b1, 2'd0, 12'h000, QID);
        for (int i = 0; i < 4; i++) r2[i] = r1[i];
        check_outs("R9 mismatch left input rank untouched");
        @(negedge clk);
        qsel = 3'd4; rd_n = 1'b0; tb_drv = 12'h6B6; tb_en = 1'b1;
        wait_n(1);
        cs_n = 1'b0;
        wait_n(6);
        chk("R9 mismatch read undriven", {36'd0, data_io}, 48'h6B6);
        cs_n = 1'b1; rd_n = 1'b1; qsel = QID;
        wait_n(6);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [1:0]  a;
            logic [11:0] d, d2;
            op = int'($urandom_range(0, 7));
            a  = 2'($urandom_range(0, 3));
            d  = 12'($urandom);
            d2 = 12'($urandom);
            case (op)
                0: begin wr(1'b1, 1'b0, a, d, QID); r1[a] = d; check_outs("R1 random write"); end
                1: begin wr(1'b1, 1'b1, a, d, QID);
                         for (int i = 0; i < 4; i++) r2[i] = r1[i];
                         check_outs("R2 random update"); end
                2: begin wr(1'b0, 1'b0, a, d, QID); m1 = d[3:0]; check_outs("R6 random mode write"); end
                3: begin wr(1'b0, 1'b1, a, d, QID); m2 = m1; check_outs("R6 random mode xfer"); end
                4: begin rd(1'b1, a, v); chk("R3 random readback", {36'd0, v}, {36'd0, r2[a]}); end
                5: begin rd(1'b0, a, v); chk("R7 random mode readback", {36'd0, v}, {44'd0, m2}); end
                6: transp(d2[0], a, d, d2, "R5 R4 random transparent");
                default: begin
                    wr(d2[1], d2[2], a, d, 3'(QID + 3'($urandom_range(1, 7))));
                    check_outs("R9 random mismatch");
                end
            endcase
        end

        // R8: asynchronous reset between clock edges
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1 model_clear();
        chk("R8 async clear codes", code_o, 48'd0);
        chk("R8 async clear mode", {44'd0, bip_o}, 48'd0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(3);
        wr(1'b1, 1'b1, 2'd0, 12'h000, QID);
        check_outs("R8 input rank cleared too");
        wr(1'b0, 1'b1, 2'd0, 12'h000, QID);
        check_outs("R8 mode input rank cleared");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule